// File: doc/BRIEF.md
# Mixed-width simple dual-port RAM

A synchronous memory with one write port and one read port sharing a single bit array. The two ports pick their data widths on their own. With widths from the 1/2/4/8/16/32 family the array holds 8192 bits. With widths from the 9/18/36 family it holds 9216 bits. Each port addresses the array in units of its own width. The block converts between the two address spaces, so a narrow port sees the slices of each wide word in order, starting with the least significant slice.

Writes are qualified by a write enable, per-lane enables and a clock enable. Reads are qualified by a read enable and a clock enable, and the read data comes out of a register. Each port has an address-stall input that reuses the address latched last time that port's clock enable was high. A parameter selects what a read returns when a write hits the same location in the same cycle: the old stored data, or an undefined value.

The active-low asynchronous reset clears only the output register and the latched addresses. The array contents are kept.

Top module: `mw_sdp_ram`

## Requirements
- R1: A read issued on a clock edge with `rd_en_i` and `rd_ce_i` high shows the addressed data on `rd_data_o` after that edge. Data written on an earlier edge is visible to the read.
- R2: Narrow word address `a`, taken against a wide word of ratio `k`, maps to wide word `a/k` and to bits `[(a%k)*Wn +: Wn]` of it. The lowest narrow address therefore selects the least significant slice. In the default shape (32-bit write, 8-bit read), read address `4*w+i` returns bits `[8*i +: 8]` of write word `w`.
- R3: Bit `b` of `wr_be_i` enables lane `[b*L +: L]` of the write word, where `L` is 8, or 9 for the parity family. Lanes whose bit is 0 keep their stored value. A write narrower than one lane uses a single enable bit.
- R4: When `rd_en_i` or `rd_ce_i` is low at a clock edge, `rd_data_o` keeps its value.
- R5: A write and a read to different locations on the same edge both take effect. The read returns the stored data at its own address.
- R6: With `OLD_DATA=1`, a read on the same edge as a write to an overlapping location returns the contents from before the write.
- R7: While `wr_stall_i` is high, a write goes to the write address latched on the last edge with `wr_ce_i` high, and `wr_addr_i` is ignored.
- R8: While `rd_stall_i` is high, a read uses the read address latched on the last edge with `rd_ce_i` high, and `rd_addr_i` is ignored.
- R9: When `wr_ce_i` is low, no write happens, even with `wr_en_i` high.
- R10: `rst_ni` low forces `rd_data_o` to zero at once, without waiting for a clock edge. The array contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous clear of the output register and the latched addresses |
| wr_en_i | input | 1 | Write request |
| wr_ce_i | input | 1 | Write port clock enable |
| wr_stall_i | input | 1 | Reuse the latched write address |
| wr_addr_i | input | WR_AW | Write address in write-width units |
| wr_data_i | input | WR_W | Write data |
| wr_be_i | input | BE_W | Per-lane write enables |
| rd_en_i | input | 1 | Read request |
| rd_ce_i | input | 1 | Read port clock enable |
| rd_stall_i | input | 1 | Reuse the latched read address |
| rd_addr_i | input | RD_AW | Read address in read-width units |
| rd_data_o | output | RD_W | Registered read data |

## Verification
A wrong slice offset or word index in the address conversion shows up as the wrong byte on `rd_data_o` one edge after the first read that crosses a slice boundary. A fault in a latched address shows up only while a stall is high, either as a write landing at the new address or as a read returning the unstalled location. Lane-enable faults stay hidden until a later read of a lane that should have been preserved, so the stimulus reads back both the enabled lanes and the disabled ones. A fault in the collision path shows up on the same edge as the colliding write.

// File: rtl/mw_ram_pkg.sv
package mw_ram_pkg;
  function automatic int lane_of(input int w);
    return (w % 9 == 0) ? 9 : 8;
  endfunction

  function automatic int bits_of(input int w);
    return (w % 9 == 0) ? 9216 : 8192;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int be_of(input int w);
    return (w < lane_of(w)) ? 1 : w / lane_of(w);
  endfunction
endpackage

// File: rtl/mw_addr_hold.sv
module mw_addr_hold #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          stall_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] held_q;

  assign addr_o = stall_i ? held_q : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= '0;
    else if (ce_i) held_q <= addr_o;
  end
endmodule

// File: rtl/mw_out_reg.sv
module mw_out_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/mw_sdp_array.sv
module mw_sdp_array
  import mw_ram_pkg::*;
#(
  parameter int WR_W     = 32,
  parameter int RD_W     = 8,
  parameter int WR_AW    = 8,
  parameter int RD_AW    = 10,
  parameter int BE_W     = 4,
  parameter bit OLD_DATA = 1'b1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [WR_AW-1:0] wa_i,
  input  logic [WR_W-1:0]  wd_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [RD_AW-1:0] ra_i,
  output logic [RD_W-1:0]  rdata_o
);
  localparam int MAX_W = max_of(WR_W, RD_W);
  localparam int DEPTH = bits_of(WR_W) / MAX_W;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int WR_SH = WR_AW - IDX_W;
  localparam int RD_SH = RD_AW - IDX_W;
  localparam int CH_W  = WR_W / BE_W;

  logic [MAX_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0] w_idx, r_idx;
  logic [31:0]      w_lane, r_lane;

  assign w_idx = wa_i[WR_AW-1 -: IDX_W];
  assign r_idx = ra_i[RD_AW-1 -: IDX_W];

  generate
    if (WR_SH > 0) begin : g_wr_lane
      assign w_lane = 32'(wa_i[WR_SH-1:0]);
    end else begin : g_wr_full
      assign w_lane = '0;
    end
    if (RD_SH > 0) begin : g_rd_lane
      assign r_lane = 32'(ra_i[RD_SH-1:0]);
    end else begin : g_rd_full
      assign r_lane = '0;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < BE_W; b++) begin
        if (be_i[b]) mem_q[w_idx][w_lane*WR_W + b*CH_W +: CH_W] <= wd_i[b*CH_W +: CH_W];
      end
    end
  end

  // bit-range overlap between the write slice and the read slice of one word
  logic [31:0]      w_lo, w_hi, r_lo, r_hi;
  logic             clash;
  logic [MAX_W-1:0] r_word;

  assign w_lo   = w_lane * WR_W;
  assign w_hi   = w_lo + WR_W;
  assign r_lo   = r_lane * RD_W;
  assign r_hi   = r_lo + RD_W;
  assign clash  = we_i && (w_idx == r_idx) && (w_lo < r_hi) && (r_lo < w_hi);
  assign r_word = mem_q[r_idx];

  always_comb begin
    rdata_o = r_word[r_lane*RD_W +: RD_W];
    if (!OLD_DATA && clash) rdata_o = 'x;
  end
endmodule

// File: rtl/mw_sdp_ram.sv
module mw_sdp_ram
  import mw_ram_pkg::*;
#(
  parameter int WR_W     = 32,
  parameter int RD_W     = 8,
  parameter bit OLD_DATA = 1'b1,
  localparam int TOTAL   = bits_of(WR_W),
  localparam int WR_AW   = $clog2(TOTAL / WR_W),
  localparam int RD_AW   = $clog2(TOTAL / RD_W),
  localparam int BE_W    = be_of(WR_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_ce_i,
  input  logic             wr_stall_i,
  input  logic [WR_AW-1:0] wr_addr_i,
  input  logic [WR_W-1:0]  wr_data_i,
  input  logic [BE_W-1:0]  wr_be_i,
  input  logic             rd_en_i,
  input  logic             rd_ce_i,
  input  logic             rd_stall_i,
  input  logic [RD_AW-1:0] rd_addr_i,
  output logic [RD_W-1:0]  rd_data_o
);
  logic [WR_AW-1:0] wr_addr_eff;
  logic [RD_AW-1:0] rd_addr_eff;
  logic [RD_W-1:0]  rd_raw;

  mw_addr_hold #(.AW(WR_AW)) i_wr_hold (
    .clk_i, .rst_ni, .ce_i(wr_ce_i), .stall_i(wr_stall_i),
    .addr_i(wr_addr_i), .addr_o(wr_addr_eff)
  );

  mw_addr_hold #(.AW(RD_AW)) i_rd_hold (
    .clk_i, .rst_ni, .ce_i(rd_ce_i), .stall_i(rd_stall_i),
    .addr_i(rd_addr_i), .addr_o(rd_addr_eff)
  );

  mw_sdp_array #(
    .WR_W(WR_W), .RD_W(RD_W), .WR_AW(WR_AW), .RD_AW(RD_AW),
    .BE_W(BE_W), .OLD_DATA(OLD_DATA)
  ) i_array (
    .clk_i,
    .we_i   (wr_en_i && wr_ce_i),
    .wa_i   (wr_addr_eff),
    .wd_i   (wr_data_i),
    .be_i   (wr_be_i),
    .ra_i   (rd_addr_eff),
    .rdata_o(rd_raw)
  );

  mw_out_reg #(.W(RD_W)) i_out (
    .clk_i, .rst_ni,
    .load_i(rd_en_i && rd_ce_i),
    .d_i   (rd_raw),
    .q_o   (rd_data_o)
  );
endmodule

// File: rtl/mw_sdp_ram_chk.sv
module mw_sdp_ram_chk #(
  parameter int WR_AW = 8,
  parameter int RD_AW = 10,
  parameter int RD_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_ce_i,
  input logic             wr_stall_i,
  input logic             rd_en_i,
  input logic             rd_ce_i,
  input logic             rd_stall_i,
  input logic [WR_AW-1:0] wr_addr_eff,
  input logic [RD_AW-1:0] rd_addr_eff,
  input logic [RD_W-1:0]  rd_data_o
);
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> rd_data_o == '0); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && rd_ce_i) |=> $stable(rd_data_o)); // R4

  AST_WR_STALL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(wr_ce_i) && wr_stall_i |-> wr_addr_eff == $past(wr_addr_eff)); // R7

  AST_RD_STALL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(rd_ce_i) && rd_stall_i |-> rd_addr_eff == $past(rd_addr_eff)); // R8
endmodule

bind mw_sdp_ram mw_sdp_ram_chk #(.WR_AW(WR_AW), .RD_AW(RD_AW), .RD_W(RD_W)) i_chk (
  .clk_i, .rst_ni, .wr_ce_i, .wr_stall_i, .rd_en_i, .rd_ce_i, .rd_stall_i,
  .wr_addr_eff, .rd_addr_eff, .rd_data_o
);

// File: tb/test_mw_sdp_ram.sv
module test_mw_sdp_ram;
  localparam int WAW = 8;
  localparam int RAW = 10;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           wr_en_i = 0, wr_ce_i = 0, wr_stall_i = 0;
  logic [WAW-1:0] wr_addr_i = '0;
  logic [31:0]    wr_data_i = '0;
  logic [3:0]     wr_be_i = '0;
  logic           rd_en_i = 0, rd_ce_i = 0, rd_stall_i = 0;
  logic [RAW-1:0] rd_addr_i = '0;
  logic [7:0]     rd_data_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  mw_sdp_ram i_mw_sdp_ram (.*);

  // {wa[8], wd[32], be[4], ra[10], exp[8]}: write, then read back one byte
  localparam logic [61:0] VEC [6] = '{
    {8'h10, 32'hA1B2C3D4, 4'hF, 10'h040, 8'hD4},
    {8'h10, 32'h00000000, 4'h0, 10'h043, 8'hA1},
    {8'h10, 32'h55667788, 4'h5, 10'h042, 8'h66},
    {8'h11, 32'h01020304, 4'hF, 10'h041, 8'hC3},
    {8'hFF, 32'hDEADBEEF, 4'hF, 10'h3FF, 8'hDE},
    {8'h00, 32'h11223344, 4'h8, 10'h003, 8'h11}
  };

  task automatic cyc(input logic we, input logic wce, input logic wst,
                     input logic [WAW-1:0] wa, input logic [31:0] wd, input logic [3:0] be,
                     input logic re, input logic rce, input logic rst, input logic [RAW-1:0] ra);
    wr_en_i = we; wr_ce_i = wce; wr_stall_i = wst; wr_addr_i = wa; wr_data_i = wd; wr_be_i = be;
    rd_en_i = re; rd_ce_i = rce; rd_stall_i = rst; rd_addr_i = ra;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [WAW-1:0] wa, input logic [31:0] wd, input logic [3:0] be);
    cyc(1, 1, 0, wa, wd, be, 0, 1, 0, '0);
  endtask

  task automatic rd(input logic [RAW-1:0] ra);
    cyc(0, 1, 0, '0, '0, '0, 1, 1, 0, ra);
  endtask

  task automatic chk(input string tag, input logic [7:0] exp);
    checks++;
    if (rd_data_o !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, rd_data_o, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset value", 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VEC[i]) begin
      wr(VEC[i][61:54], VEC[i][53:22], VEC[i][21:18]);
      rd(VEC[i][17:8]);
      chk($sformatf("R1/R2/R3 vec %0d", i), VEC[i][7:0]);
    end

    // R4: idle read enable, then idle clock enable
    rd(10'h040);
    cyc(0, 1, 0, '0, '0, '0, 0, 1, 0, 10'h043);
    chk("R4 rd_en low hold", 8'h88);
    cyc(0, 1, 0, '0, '0, '0, 1, 0, 0, 10'h043);
    chk("R4 rd_ce low hold", 8'h88);

    // R5: concurrent write and read at different locations
    cyc(1, 1, 0, 8'h20, 32'h9ABCDEF0, 4'hF, 1, 1, 0, 10'h044);
    chk("R5 concurrent read", 8'h04);
    rd(10'h080);
    chk("R5 concurrent write", 8'hF0);

    // R6: same-location collision returns old data
    cyc(1, 1, 0, 8'h10, 32'hFFFFFFFF, 4'hF, 1, 1, 0, 10'h040);
    chk("R6 old data", 8'h88);
    rd(10'h040);
    chk("R6 new data after", 8'hFF);

    // R7: write address stall
    wr(8'h31, 32'h00000000, 4'hF);
    wr(8'h30, 32'hCAFEF00D, 4'hF);
    cyc(1, 1, 1, 8'h31, 32'h12345678, 4'hF, 0, 1, 0, '0);
    rd(10'h0C0);
    chk("R7 stalled write target", 8'h78);
    rd(10'h0C4);
    chk("R7 ignored address", 8'h00);

    // R8: read address stall
    rd(10'h040);
    cyc(0, 1, 0, '0, '0, '0, 1, 1, 1, 10'h3FF);
    chk("R8 stalled read", 8'hFF);

    // R9: write clock enable low
    cyc(1, 0, 0, 8'h10, 32'h00000000, 4'hF, 0, 1, 0, '0);
    rd(10'h041);
    chk("R9 no write", 8'hFF);

    // R10: asynchronous clear keeps the array
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R10 async clear", 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(10'h041);
    chk("R10 array retained", 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule